// File: doc/BRIEF.md
# Multi-Source XOR Engine with Zero Check

This block carries out one descriptor of an XOR offload engine. A channel controller hands it a control word, a byte count, a destination address, a 32-bit fill pattern and up to sixteen source addresses, then pulses `start`. The engine walks the buffer one 32-bit word at a time. For each word offset it reads every selected source, folds the words together with XOR, and then either writes the result to the destination or, in check mode, only records whether the result was non-zero. A third mode writes the fill pattern over the whole destination without reading anything.

Memory traffic uses three valid/ready channels: a read request channel (`rd_valid`/`rd_ready` with `rd_addr`), a read data channel (`rdata_valid`/`rdata_ready` with `rdata`) and a write channel (`wr_valid`/`wr_ready` with `wr_addr`/`wr_data`). Back-pressure rule: once a valid is raised, it stays high and its payload stays unchanged until the cycle in which ready is also high. The engine keeps at most one read in flight. It raises `rdata_ready` only while it waits for that read. Read and write requests are never offered in the same cycle. When the descriptor ends, the engine pulses `done` for one cycle and holds a status word until the next accepted start.

Top module: `xor_zero_engine`

## Requirements
- R1: After reset `busy`, `done`, `rd_valid`, `wr_valid` and `rdata_ready` are 0 and `status_word` is 0. While `busy` is low, no read or write request is offered.
- R2: In XOR mode (control bits 7 and 8 both 0), the sources are read for every word offset k = 0,1,.. The reads go to source n at `src_addr[n] + 4k`, with n ascending from 0. After them comes exactly one write of their XOR to `dst_addr + 4k`.
- R3: Control bits 6:3 hold the number of sources minus one. The value 0 reads one source, which is a plain copy, and the value 15 reads all sixteen. Source n's address is `src_addr_flat[32n+31:32n]`.
- R4: In check mode (control bit 7 = 1, bit 8 = 0), reads happen as in R2 and no write is ever issued. Status bit 30 ends at 1 exactly when the XOR at some offset was non-zero and control bit 12 is 1.
- R5: With control bit 12 = 0, status bit 30 stays 0 even when the XOR is non-zero.
- R6: Control bit 8 selects fill. No reads are issued, and `fill_pattern` is written to `dst_addr + 4k` for every word. Fill takes priority over bit 7.
- R7: A byte count that is 0 or not a multiple of 4, or a control field in bits 2:1 other than 3 (local memory towards the internal bus), produces no memory traffic. `done` still pulses.
- R8: `done` is a one-cycle pulse that follows the final write handshake (in check mode, the final read data). `busy` is high from the cycle after an accepted start through the `done` cycle. From the `done` cycle until the next accepted start, `status_word` reads bit 31 = 1, bit 30 as in R4/R5, bits 29:24 = 0 and bits 23:0 = byte count.
- R9: A `start` is accepted only while `busy` is low. A start while busy, including one in the `done` cycle, has no effect on traffic, `busy` or status.
- R10: `rd_valid`/`rd_addr` and `wr_valid`/`wr_addr`/`wr_data` hold until their ready. At most one read is outstanding. Read and write requests never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a descriptor (accepted when idle) |
| ctrl_word | input | 32 | Descriptor control word |
| byte_count | input | 24 | Transfer length in bytes |
| dst_addr | input | 32 | Destination byte address |
| fill_pattern | input | 32 | Constant for fill mode |
| src_addr_flat | input | 512 | Sixteen source byte addresses, source n at bits 32n+31:32n |
| busy | output | 1 | Descriptor in progress |
| done | output | 1 | One-cycle completion pulse |
| status_word | output | 32 | Completion status |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read byte address |
| rdata_valid | input | 1 | Read data valid |
| rdata | input | 32 | Read data |
| rdata_ready | output | 1 | Engine can take read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |

## Verification
Two things can land in one cycle here: a new `start` from the controller and the `done` of the descriptor still in progress. The bench raises `start` in exactly the cycle where it sees `done`, using a different control word. It then requires that `busy` stays low, that no further request appears and that the status word keeps its completed value. A second case raises `start` in the middle of a run and requires the traffic to match the first descriptor exactly. Both cases run under memory back-pressure, so that the read accept, the read data and the write handshake each fall in different cycles.

// File: rtl/xze_pkg.sv
package xze_pkg;
  localparam int CW_DIR_LSB  = 1;
  localparam int CW_SRC_LSB  = 3;
  localparam int CW_ZERO_BIT = 7;
  localparam int CW_FILL_BIT = 8;
  localparam int CW_WB_BIT   = 12;
  localparam int ST_ERR_BIT  = 30;
  localparam int ST_DONE_BIT = 31;
  localparam logic [1:0] DIR_LOCAL_TO_INT = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_RSP  = 3'd2,
    S_WR   = 3'd3,
    S_FIN  = 3'd4
  } xze_state_e;
endpackage

// File: rtl/xze_ctrl_decode.sv
module xze_ctrl_decode #(
  parameter int BC_W      = 24,
  parameter int SRC_IDX_W = 4
) (
  input  logic [31:0]          ctrl_word,
  input  logic [BC_W-1:0]      byte_count,
  output logic [SRC_IDX_W-1:0] src_last,
  output logic                 zero_only,
  output logic                 fill_mode,
  output logic                 wb_en,
  output logic                 runnable,
  output logic [BC_W-3:0]      word_last
);
  import xze_pkg::*;

  logic dir_ok;
  logic len_ok;

  always_comb begin
    src_last  = ctrl_word[CW_SRC_LSB +: SRC_IDX_W];
    fill_mode = ctrl_word[CW_FILL_BIT];
    zero_only = ctrl_word[CW_ZERO_BIT] & ~ctrl_word[CW_FILL_BIT];
    wb_en     = ctrl_word[CW_WB_BIT];
    dir_ok    = (ctrl_word[CW_DIR_LSB +: 2] == DIR_LOCAL_TO_INT);
    len_ok    = (byte_count != '0) && (byte_count[1:0] == 2'b00);
    runnable  = dir_ok & len_ok;
    word_last = byte_count[BC_W-1:2] - 1'b1;
  end
endmodule

// File: rtl/xze_addr_gen.sv
module xze_addr_gen #(
  parameter int NUM_SRC   = 16,
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 22,
  parameter int SRC_IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NUM_SRC*ADDR_W-1:0] src_addr_flat,
  input  logic [ADDR_W-1:0]         dst_addr,
  input  logic [SRC_IDX_W-1:0]      src_idx,
  input  logic [WORD_W-1:0]         word_idx,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic [ADDR_W-1:0]         wr_addr
);
  logic [ADDR_W-1:0] src_q [NUM_SRC];
  logic [ADDR_W-1:0] dst_q;
  logic [ADDR_W-1:0] offset;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    src_q[g] <= '0;
      else if (load) src_q[g] <= src_addr_flat[g*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dst_q <= '0;
    else if (load) dst_q <= dst_addr;
  end

  always_comb begin
    offset  = ADDR_W'({word_idx, 2'b00});
    rd_addr = src_q[src_idx] + offset;
    wr_addr = dst_q + offset;
  end
endmodule

// File: rtl/xze_accum.sv
module xze_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              first,
  input  logic              check,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc,
  output logic              nz_flag,
  output logic              nz_next
);
  logic [DATA_W-1:0] acc_next;

  always_comb begin
    acc_next = first ? din : (acc ^ din);
    nz_next  = nz_flag | (check && (acc_next != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      nz_flag <= 1'b0;
    end else if (clear) begin
      acc     <= '0;
      nz_flag <= 1'b0;
    end else if (capture) begin
      acc     <= acc_next;
      nz_flag <= nz_next;
    end
  end
endmodule

// File: rtl/xor_zero_engine.sv
module xor_zero_engine #(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BC_W    = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [31:0]               ctrl_word,
  input  logic [BC_W-1:0]           byte_count,
  input  logic [ADDR_W-1:0]         dst_addr,
  input  logic [DATA_W-1:0]         fill_pattern,
  input  logic [NUM_SRC*ADDR_W-1:0] src_addr_flat,
  output logic                      busy,
  output logic                      done,
  output logic [31:0]               status_word,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic [ADDR_W-1:0]         rd_addr,
  input  logic                      rdata_valid,
  input  logic [DATA_W-1:0]         rdata,
  output logic                      rdata_ready,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [DATA_W-1:0]         wr_data
);
  import xze_pkg::*;

  localparam int SRC_IDX_W = $clog2(NUM_SRC);
  localparam int WORD_W    = BC_W - 2;

  xze_state_e state_q, state_d;

  logic [SRC_IDX_W-1:0] src_idx_q, src_last_q, dec_src_last;
  logic [WORD_W-1:0]    word_q, word_last_q, dec_word_last;
  logic                 zero_only_q, fill_q, wb_q;
  logic                 dec_zero_only, dec_fill, dec_wb, dec_runnable;
  logic [DATA_W-1:0]    pattern_q;
  logic [BC_W-1:0]      bc_q;
  logic [31:0]          status_q;
  logic                 accept, rsp_take, wr_take, last_src, last_word, fin_enter;
  logic [DATA_W-1:0]    acc;
  logic                 nz_flag, nz_next;

  xze_ctrl_decode #(.BC_W(BC_W), .SRC_IDX_W(SRC_IDX_W)) i_decode (
    .ctrl_word  (ctrl_word),
    .byte_count (byte_count),
    .src_last   (dec_src_last),
    .zero_only  (dec_zero_only),
    .fill_mode  (dec_fill),
    .wb_en      (dec_wb),
    .runnable   (dec_runnable),
    .word_last  (dec_word_last)
  );

  xze_addr_gen #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SRC_IDX_W(SRC_IDX_W)
  ) i_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (accept),
    .src_addr_flat (src_addr_flat),
    .dst_addr      (dst_addr),
    .src_idx       (src_idx_q),
    .word_idx      (word_q),
    .rd_addr       (rd_addr),
    .wr_addr       (wr_addr)
  );

  xze_accum #(.DATA_W(DATA_W)) i_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (rsp_take),
    .first   (src_idx_q == '0),
    .check   (rsp_take && last_src && zero_only_q),
    .din     (rdata),
    .acc     (acc),
    .nz_flag (nz_flag),
    .nz_next (nz_next)
  );

  always_comb begin
    accept    = start && (state_q == S_IDLE);
    rsp_take  = (state_q == S_RSP) && rdata_valid;
    wr_take   = (state_q == S_WR) && wr_ready;
    last_src  = (src_idx_q == src_last_q);
    last_word = (word_q == word_last_q);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          if (!dec_runnable) state_d = S_FIN;
          else if (dec_fill) state_d = S_WR;
          else               state_d = S_RD;
        end
      end
      S_RD:  if (rd_ready) state_d = S_RSP;
      S_RSP: begin
        if (rdata_valid) begin
          if (!last_src)        state_d = S_RD;
          else if (!zero_only_q) state_d = S_WR;
          else if (last_word)   state_d = S_FIN;
          else                  state_d = S_RD;
        end
      end
      S_WR: begin
        if (wr_ready) begin
          if (last_word)   state_d = S_FIN;
          else if (fill_q) state_d = S_WR;
          else             state_d = S_RD;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    fin_enter = (state_d == S_FIN) && (state_q != S_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_last_q  <= '0;
      word_last_q <= '0;
      zero_only_q <= 1'b0;
      fill_q      <= 1'b0;
      wb_q        <= 1'b0;
      pattern_q   <= '0;
      bc_q        <= '0;
    end else if (accept) begin
      src_last_q  <= dec_src_last;
      word_last_q <= dec_word_last;
      zero_only_q <= dec_zero_only & dec_runnable;
      fill_q      <= dec_fill;
      wb_q        <= dec_wb;
      pattern_q   <= fill_pattern;
      bc_q        <= byte_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_idx_q <= '0;
      word_q    <= '0;
    end else if (accept) begin
      src_idx_q <= '0;
      word_q    <= '0;
    end else begin
      if (rsp_take) begin
        if (last_src) begin
          src_idx_q <= '0;
          if (zero_only_q && !last_word) word_q <= word_q + 1'b1;
        end else begin
          src_idx_q <= src_idx_q + 1'b1;
        end
      end
      if (wr_take && !last_word) word_q <= word_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (fin_enter) begin
      status_q                 <= '0;
      status_q[ST_DONE_BIT]    <= 1'b1;
      status_q[ST_ERR_BIT]     <= accept ? 1'b0 : (nz_next & wb_q);
      status_q[BC_W-1:0]       <= accept ? byte_count : bc_q;
    end else if (accept) begin
      status_q <= '0;
    end
  end

  always_comb begin
    busy        = (state_q != S_IDLE);
    done        = (state_q == S_FIN);
    rd_valid    = (state_q == S_RD);
    rdata_ready = (state_q == S_RSP);
    wr_valid    = (state_q == S_WR);
    wr_data     = fill_q ? pattern_q : acc;
    status_word = status_q;
  end
endmodule

// File: rtl/xze_checks.sv
module xze_checks #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rdata_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [31:0]       status_word,
  input logic              zero_only,
  input logic              wb_en
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rdata_ready); // R10
  AST_CHECK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_only |-> !wr_valid); // R4
  AST_ERR_NEEDS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[30] |-> wb_en); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status_word[31]); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !wr_valid); // R1
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start |=> busy); // R9
endmodule

bind xor_zero_engine xze_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_xze_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_addr     (rd_addr),
  .rdata_ready (rdata_ready),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .status_word (status_word),
  .zero_only   (zero_only_q),
  .wb_en       (wb_q)
);

// File: tb/test_xor_zero_engine.sv
`timescale 1ns/1ps
module test_xor_zero_engine;
  localparam int NSRC     = 16;
  localparam int SRC_BASE = 32'h400;
  localparam int SRC_STEP = 64;
  localparam int DST_BASE = 32'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [23:0] byte_count = '0;
  logic [31:0] dst_addr = DST_BASE;
  logic [31:0] fill_pattern = '0;
  logic [NSRC*32-1:0] src_addr_flat;
  logic busy, done, rd_valid, rdata_ready, wr_valid;
  logic [31:0] status_word, rd_addr, wr_addr, wr_data;
  logic rd_ready = 1'b0, rdata_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] rdata = '0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < NSRC; g++) begin : g_sa
    assign src_addr_flat[g*32 +: 32] = SRC_BASE + g*SRC_STEP;
  end

  xor_zero_engine i_xor_zero_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .byte_count(byte_count), .dst_addr(dst_addr), .fill_pattern(fill_pattern),
    .src_addr_flat(src_addr_flat), .busy(busy), .done(done),
    .status_word(status_word), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rdata_valid(rdata_valid), .rdata(rdata),
    .rdata_ready(rdata_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic [31:0] mem [1024];
  logic [31:0] exp_rd [512];
  logic [31:0] exp_wa [64];
  logic [31:0] exp_wd [64];
  int exp_rd_n, exp_wr_n;
  string cur_req = "R2";

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int mon_rd_i = 0, mon_wr_i = 0;
  logic [1:0] cyc = '0;

  // memory model with back-pressure; checks traffic order in place
  always @(posedge clk) begin
    cyc      <= cyc + 1'b1;
    rd_ready <= (cyc != 2'd1);
    wr_ready <= (cyc != 2'd3);
    if (start && !busy) begin
      mon_rd_i <= 0;
      mon_wr_i <= 0;
    end else begin
      if (rd_valid && rd_ready) begin
        mon_checks <= mon_checks + 1;
        if (mon_rd_i >= exp_rd_n || rd_addr != exp_rd[mon_rd_i]) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL %s read #%0d addr act=%h exp=%h", cur_req, mon_rd_i,
                   rd_addr, (mon_rd_i < exp_rd_n) ? exp_rd[mon_rd_i] : 32'hFFFFFFFF);
        end
        mon_rd_i <= mon_rd_i + 1;
      end
      if (wr_valid && wr_ready) begin
        mon_checks <= mon_checks + 1;
        if (mon_wr_i >= exp_wr_n || wr_addr != exp_wa[mon_wr_i] || wr_data != exp_wd[mon_wr_i]) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL %s write #%0d act=%h/%h exp=%h/%h", cur_req, mon_wr_i, wr_addr, wr_data,
                   (mon_wr_i < exp_wr_n) ? exp_wa[mon_wr_i] : 32'hFFFFFFFF,
                   (mon_wr_i < exp_wr_n) ? exp_wd[mon_wr_i] : 32'hFFFFFFFF);
        end
        mon_wr_i <= mon_wr_i + 1;
      end
    end
    if (rd_valid && rd_ready) begin
      rdata       <= mem[rd_addr[11:2]];
      rdata_valid <= 1'b1;
    end else if (rdata_valid && rdata_ready) begin
      rdata_valid <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(int nsrc, bit zero, bit fill, bit wb, logic [1:0] dir);
    logic [31:0] c = '0;
    c[2:1]  = dir;
    c[6:3]  = 4'(nsrc - 1);
    c[7]    = zero;
    c[8]    = fill;
    c[12]   = wb;
    return c;
  endfunction

  // poke: 1 = start again while busy, 2 = start in the done cycle
  task automatic run_desc(input string req, input logic [31:0] ctl, input logic [23:0] bc,
                          input logic [31:0] pat, input int poke);
    int nsrc = int'(ctl[6:3]) + 1;
    bit ok = (ctl[2:1] == 2'b11) && (bc != 0) && (bc[1:0] == 2'b00);
    bit err = 1'b0;
    int wait_n = 0;
    logic [31:0] exp_st;
    cur_req  = req;
    exp_rd_n = 0;
    exp_wr_n = 0;
    if (ok) begin
      for (int k = 0; k < int'(bc) / 4; k++) begin
        logic [31:0] x = '0;
        if (ctl[8]) begin
          exp_wa[exp_wr_n] = DST_BASE + 4*k; exp_wd[exp_wr_n] = pat; exp_wr_n++;
        end else begin
          for (int n = 0; n < nsrc; n++) begin
            logic [31:0] a = SRC_BASE + n*SRC_STEP + 4*k;
            exp_rd[exp_rd_n] = a; exp_rd_n++;
            x ^= mem[a[11:2]];
          end
          if (ctl[7]) begin
            if (x != 0) err = 1'b1;
          end else begin
            exp_wa[exp_wr_n] = DST_BASE + 4*k; exp_wd[exp_wr_n] = x; exp_wr_n++;
          end
        end
      end
    end
    exp_st = {1'b1, err && ctl[12] && ctl[7] && !ctl[8] && ok, 6'b0, bc};
    @(negedge clk);
    ctrl_word = ctl; byte_count = bc; fill_pattern = pat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ok) chk({req, " busy after start (R8)"}, 32'(busy), 32'd1);
    if (poke == 1) begin
      repeat (4) @(negedge clk);
      ctrl_word = mk_ctrl(1, 0, 1, 0, 2'b11); byte_count = 24'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && wait_n < 4000) begin
      @(negedge clk);
      wait_n++;
    end
    chk({req, " done seen (R8)"}, 32'(done), 32'd1);
    chk({req, " status (R8)"}, status_word, exp_st);
    if (poke == 2) begin
      ctrl_word = mk_ctrl(1, 0, 1, 0, 2'b11); byte_count = 24'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 start in done cycle: busy", 32'(busy), 32'd0);
    end
    @(negedge clk);
    chk({req, " done is one cycle (R8)"}, 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk({req, " read count"}, 32'(mon_rd_i), 32'(exp_rd_n));
    chk({req, " write count"}, 32'(mon_wr_i), 32'(exp_wr_n));
    chk({req, " status held (R8)"}, status_word, exp_st);
    chk({req, " idle (R1)"}, 32'(busy), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 wr_valid", 32'(wr_valid), 32'd0);
    chk("R1 rdata_ready", 32'(rdata_ready), 32'd0);
    chk("R1 status", status_word, 32'd0);
  endtask

  task automatic t_xor();
    run_desc("R2 xor 3 src", mk_ctrl(3, 0, 0, 0, 2'b11), 24'd20, 32'h0, 0);
    run_desc("R3 one src copy", mk_ctrl(1, 0, 0, 0, 2'b11), 24'd16, 32'h0, 0);
    run_desc("R3 sixteen src", mk_ctrl(16, 0, 0, 0, 2'b11), 24'd8, 32'h0, 0);
  endtask

  task automatic t_check();
    for (int k = 0; k < 4; k++)
      mem[(SRC_BASE + 2*SRC_STEP)/4 + k] = mem[SRC_BASE/4 + k] ^ mem[(SRC_BASE + SRC_STEP)/4 + k];
    run_desc("R4 check clean", mk_ctrl(3, 1, 0, 1, 2'b11), 24'd16, 32'h0, 0);
    mem[(SRC_BASE + 2*SRC_STEP)/4 + 3] = ~mem[(SRC_BASE + 2*SRC_STEP)/4 + 3];
    run_desc("R4 check dirty", mk_ctrl(3, 1, 0, 1, 2'b11), 24'd16, 32'h0, 0);
    run_desc("R5 dirty no writeback", mk_ctrl(3, 1, 0, 0, 2'b11), 24'd16, 32'h0, 0);
  endtask

  task automatic t_fill();
    run_desc("R6 fill", mk_ctrl(4, 0, 1, 0, 2'b11), 24'd24, 32'hA5C3_0F1E, 0);
    run_desc("R6 fill over check", mk_ctrl(2, 1, 1, 1, 2'b11), 24'd12, 32'h1357_9BDF, 0);
  endtask

  task automatic t_bad();
    run_desc("R7 odd length", mk_ctrl(2, 0, 0, 0, 2'b11), 24'd6, 32'h0, 0);
    run_desc("R7 zero length", mk_ctrl(2, 0, 0, 0, 2'b11), 24'd0, 32'h0, 0);
    run_desc("R7 wrong direction", mk_ctrl(2, 0, 0, 0, 2'b10), 24'd8, 32'h0, 0);
  endtask

  task automatic t_busy_start();
    run_desc("R9 start while busy", mk_ctrl(2, 0, 0, 0, 2'b11), 24'd12, 32'h0, 1);
    run_desc("R9 start in done cycle", mk_ctrl(2, 0, 0, 0, 2'b11), 24'd8, 32'h0, 2);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0001;
    exp_rd_n = 0;
    exp_wr_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_xor();
    t_check();
    t_fill();
    t_bad();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end
endmodule